// File: doc/BRIEF.md
# Interleaved Multi-Channel Running-Sum Generator

This block fills on-chip storage with a set of independent running-sum sequences. Every channel begins at a seed equal to its own channel number. Each later element adds its element index to that channel's previous element. A single recurrence chain cannot issue faster than the latency of its adder allows, because every element waits for the one before it. To avoid that limit, the generator steps through the channels round-robin with the channel index changing fastest. A channel's previous sum has therefore left the multi-stage adder before that channel comes round again, and each lane accepts one new element on every clock.

Several identical lanes run side by side. Each lane has its own result bank and its own per-channel record of the latest value, and no data passes between lanes. The user pulses `start`, waits for the single-cycle `done` pulse, and then reads any element of any lane through a synchronous read port.

Top module: `rrg_top`

## Requirements
- R1: After reset, `done` is 0 and `rd_data` is 0 until the first read completes.
- R2: Element 0 of channel j holds the value j in every lane.
- R3: For i > 0, element i of a channel equals element i-1 of that channel plus i, modulo 2^DATA_W. For example, with 16-bit data, channel 0 element 362 holds 167.
- R4: Step counter k visits channel k mod CHANS and element k / CHANS, so the channel changes fastest. Each lane takes one step per clock, and the result of step k lands at bank address k.
- R5: `done` is high for exactly one cycle. That cycle is CHANS*SEQ_LEN + ADD_LAT + 1 clock edges after the edge that samples `start`, counting that edge as the first.
- R6: A `start` pulse that arrives while a run is in progress is ignored. The run's `done` timing, the number of `done` pulses and the stored results stay the same.
- R7: Each of the LANES lanes writes the full set of CHANS*SEQ_LEN elements into its own bank. `rd_lane` selects the bank to read.
- R8: A read presented on `rd_lane`/`rd_chan`/`rd_idx` appears on `rd_data` after the next clock edge. Back-to-back reads are accepted every cycle.
- R9: A new `start` after `done` runs the whole generation again and leaves the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| done | output | 1 | One-cycle pulse after the final write of all lanes |
| rd_lane | input | LW | Lane (bank) to read |
| rd_chan | input | CH_W | Channel to read |
| rd_idx | input | IDX_W | Element index to read |
| rd_data | output | DATA_W | Read result, one cycle after the request |

## Verification
Several properties are checked on every cycle. The assertions confirm that the step counter's address always agrees with its channel and element counters. They confirm that the channel leaving the adder pipeline never matches the channel being issued, so the register-file hazard never happens. They also check that the lanes finish in lockstep, that `done` never lasts two cycles, and that a run cannot be cut short by `start`. The stored values can only be shown by the bench scenarios: the seeds, the recurrence including its modulo wrap, the exact `done` latency, the ignored mid-run start, the restart, and random back-to-back reads of both banks.

// File: rtl/rrg_pkg.sv
package rrg_pkg;
   // width of an index able to address n items, never below one bit
   function automatic int unsigned bits_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rrg_step_ctr.sv
module rrg_step_ctr #(
   parameter int unsigned CHANS   = 10,
   parameter int unsigned SEQ_LEN = 100,
   localparam int unsigned CH_W   = rrg_pkg::bits_for(CHANS),
   localparam int unsigned IDX_W  = rrg_pkg::bits_for(SEQ_LEN),
   localparam int unsigned ADDR_W = rrg_pkg::bits_for(CHANS * SEQ_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              iss_valid,
   output logic [CH_W-1:0]   iss_chan,
   output logic [IDX_W-1:0]  iss_idx,
   output logic [ADDR_W-1:0] iss_addr,
   output logic              iss_last
);
   localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(CHANS - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SEQ_LEN - 1);

   logic busy;

   assign iss_valid = busy;
   assign iss_last  = busy && (iss_chan == CH_LAST) && (iss_idx == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         iss_chan <= '0;
         iss_idx  <= '0;
         iss_addr <= '0;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            iss_chan <= '0;
            iss_idx  <= '0;
            iss_addr <= '0;
         end
      end else begin
         iss_addr <= iss_addr + 1'b1;
         if (iss_chan == CH_LAST) begin
            iss_chan <= '0;
            iss_idx  <= iss_idx + 1'b1;
         end else begin
            iss_chan <= iss_chan + 1'b1;
         end
         if (iss_last) busy <= 1'b0;
      end
   end

   // R4: linear address agrees with the separate channel and element counters
   a_r4_addr_map: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> iss_addr == ADDR_W'(iss_idx) * ADDR_W'(CHANS) + ADDR_W'(iss_chan));

   // R6: a run is never cut short, whatever start does
   a_r6_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_last) |=> iss_valid);
endmodule

// File: rtl/rrg_add_pipe.sv
module rrg_add_pipe #(
   parameter int unsigned DEPTH  = 6,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CH_W   = 4,
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_v,
   input  logic              in_last,
   input  logic [CH_W-1:0]   in_chan,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_v,
   output logic              out_last,
   output logic [CH_W-1:0]   out_chan,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_data
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("rrg_add_pipe: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0]  vld;
   logic [DEPTH-1:0]  lst;
   logic [CH_W-1:0]   chn [DEPTH];
   logic [ADDR_W-1:0] adr [DEPTH];
   logic [DATA_W-1:0] dat [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         lst <= '0;
      end else begin
         vld[0] <= in_v;
         lst[0] <= in_v && in_last;
         for (int s = 1; s < DEPTH; s++) begin
            vld[s] <= vld[s-1];
            lst[s] <= lst[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      chn[0] <= in_chan;
      adr[0] <= in_addr;
      dat[0] <= in_data;
      for (int s = 1; s < DEPTH; s++) begin
         chn[s] <= chn[s-1];
         adr[s] <= adr[s-1];
         dat[s] <= dat[s-1];
      end
   end

   assign out_v    = vld[DEPTH-1];
   assign out_last = lst[DEPTH-1];
   assign out_chan = chn[DEPTH-1];
   assign out_addr = adr[DEPTH-1];
   assign out_data = dat[DEPTH-1];
endmodule

// File: rtl/rrg_lane.sv
module rrg_lane #(
   parameter int unsigned CHANS   = 10,
   parameter int unsigned SEQ_LEN = 100,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADD_LAT = 6,
   localparam int unsigned DEPTH  = CHANS * SEQ_LEN,
   localparam int unsigned CH_W   = rrg_pkg::bits_for(CHANS),
   localparam int unsigned IDX_W  = rrg_pkg::bits_for(SEQ_LEN),
   localparam int unsigned ADDR_W = rrg_pkg::bits_for(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic              iss_last,
   input  logic [CH_W-1:0]   iss_chan,
   input  logic [IDX_W-1:0]  iss_idx,
   input  logic [ADDR_W-1:0] iss_addr,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_q,
   output logic              wr_last
);
   logic [DATA_W-1:0] last_val [CHANS];
   logic [DATA_W-1:0] bank     [DEPTH];
   logic [DATA_W-1:0] iss_sum;

   logic              wv, wl;
   logic [CH_W-1:0]   wchan;
   logic [ADDR_W-1:0] waddr;
   logic [DATA_W-1:0] wdata;

   // seed on element 0, otherwise previous value of the channel plus index
   always_comb begin
      if (iss_idx == '0) iss_sum = DATA_W'(iss_chan);
      else               iss_sum = last_val[iss_chan] + DATA_W'(iss_idx);
   end

   rrg_add_pipe #(
      .DEPTH (ADD_LAT),
      .DATA_W(DATA_W),
      .CH_W  (CH_W),
      .ADDR_W(ADDR_W)
   ) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (iss_valid),
      .in_last (iss_last),
      .in_chan (iss_chan),
      .in_addr (iss_addr),
      .in_data (iss_sum),
      .out_v   (wv),
      .out_last(wl),
      .out_chan(wchan),
      .out_addr(waddr),
      .out_data(wdata)
   );

   always_ff @(posedge clk) begin
      if (wv) begin
         bank[waddr]     <= wdata;
         last_val[wchan] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= bank[rd_addr];
   end

   assign wr_last = wv && wl;

   // R3: a channel being issued is never still in flight through the adder
   a_r3_no_hazard: assert property (@(posedge clk) disable iff (!rst_n)
      (wv && iss_valid) |-> wchan != iss_chan);
endmodule

// File: rtl/rrg_top.sv
module rrg_top #(
   parameter int unsigned LANES   = 2,
   parameter int unsigned CHANS   = 10,
   parameter int unsigned SEQ_LEN = 100,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADD_LAT = 6,
   localparam int unsigned LW     = rrg_pkg::bits_for(LANES),
   localparam int unsigned CH_W   = rrg_pkg::bits_for(CHANS),
   localparam int unsigned IDX_W  = rrg_pkg::bits_for(SEQ_LEN),
   localparam int unsigned ADDR_W = rrg_pkg::bits_for(CHANS * SEQ_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              done,
   input  logic [LW-1:0]     rd_lane,
   input  logic [CH_W-1:0]   rd_chan,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   if (CHANS <= ADD_LAT) begin : g_bad_spacing
      $error("rrg_top: CHANS must exceed ADD_LAT to hide the adder latency");
   end
   if (LANES < 1 || SEQ_LEN < 2 || CHANS < 2) begin : g_bad_size
      $error("rrg_top: LANES >= 1, CHANS >= 2 and SEQ_LEN >= 2 required");
   end

   logic              iss_valid, iss_last;
   logic [CH_W-1:0]   iss_chan;
   logic [IDX_W-1:0]  iss_idx;
   logic [ADDR_W-1:0] iss_addr;
   logic [ADDR_W-1:0] rd_addr;
   logic [LW-1:0]     sel_q;
   logic [LANES-1:0]  wr_last_vec;
   logic [DATA_W-1:0] lane_q [LANES];

   rrg_step_ctr #(.CHANS(CHANS), .SEQ_LEN(SEQ_LEN)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .iss_valid(iss_valid),
      .iss_chan (iss_chan),
      .iss_idx  (iss_idx),
      .iss_addr (iss_addr),
      .iss_last (iss_last)
   );

   assign rd_addr = ADDR_W'(rd_idx) * ADDR_W'(CHANS) + ADDR_W'(rd_chan);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      rrg_lane #(
         .CHANS  (CHANS),
         .SEQ_LEN(SEQ_LEN),
         .DATA_W (DATA_W),
         .ADD_LAT(ADD_LAT)
      ) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .iss_valid(iss_valid),
         .iss_last (iss_last),
         .iss_chan (iss_chan),
         .iss_idx  (iss_idx),
         .iss_addr (iss_addr),
         .rd_addr  (rd_addr),
         .rd_q     (lane_q[g]),
         .wr_last  (wr_last_vec[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         sel_q <= '0;
      end else begin
         done  <= &wr_last_vec;
         sel_q <= rd_lane;
      end
   end

   assign rd_data = lane_q[sel_q];

   // R5: done never lasts more than one cycle
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: independent lanes still finish their final write together
   a_r7_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      wr_last_vec[0] == wr_last_vec[LANES-1]);
endmodule

// File: tb/sim_rrg_top.sv
module sim_rrg_top;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 2;
   localparam int CHANS = 10;
   localparam int SEQ   = 370;
   localparam int LAT   = 6;
   localparam int LW    = 1;
   localparam int CH_W  = 4;
   localparam int IDX_W = 9;
   localparam int EXP_DONE = CHANS * SEQ + LAT + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic done;
   logic [LW-1:0]    rd_lane = '0;
   logic [CH_W-1:0]  rd_chan = '0;
   logic [IDX_W-1:0] rd_idx  = '0;
   logic [15:0]      rd_data;

   int n_tests = 0;
   int n_fail  = 0;

   rrg_top #(.LANES(LANES), .CHANS(CHANS), .SEQ_LEN(SEQ), .DATA_W(16), .ADD_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .done(done),
      .rd_lane(rd_lane), .rd_chan(rd_chan), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] exp_val(input int ch, input int idx);
      int unsigned s;
      s = ch + (idx * (idx + 1)) / 2;
      return s[15:0];
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // single read: address at negedge, data sampled one edge later
   task automatic rd(input int ln, input int ch, input int ix, output int val);
      @(negedge clk);
      rd_lane = LW'(ln); rd_chan = CH_W'(ch); rd_idx = IDX_W'(ix);
      @(negedge clk);
      val = int'(rd_data);
   endtask

   // run generation; optional extra start pulse at cycle extra_at (0 = none)
   task automatic run(input string req, input int extra_at);
      int cnt;
      int pulses;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cnt = 1; pulses = 0;
      while (!done && cnt < EXP_DONE + 50) begin
         start = (cnt == extra_at || cnt == extra_at + 1) && extra_at != 0;
         @(negedge clk);
         cnt++;
      end
      start = 1'b0;
      check({req, " done latency"}, cnt, EXP_DONE);
      for (int w = 0; w < 30; w++) begin
         @(negedge clk);
         if (done) pulses++;
      end
      check({req, " done single pulse"}, pulses, 0);
   endtask

   task automatic full_readback(input string req);
      int v;
      int bad;
      bad = 0;
      for (int ln = 0; ln < LANES; ln++)
         for (int ix = 0; ix < SEQ; ix++)
            for (int ch = 0; ch < CHANS; ch++) begin
               rd(ln, ch, ix, v);
               if (v != int'(exp_val(ch, ix))) begin
                  bad++;
                  if (bad < 6)
                     $display("FAIL %s lane %0d ch %0d idx %0d actual=%0d expected=%0d",
                              req, ln, ch, ix, v, exp_val(ch, ix));
               end
            end
      n_tests++;
      if (bad != 0) n_fail++;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int v;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 done at reset", int'(done), 0);
      check("R1 rd_data at reset", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 done idle", int'(done), 0);

      // R4 R5: first run, one step per clock visible in done latency
      run("R4 R5 run1", 0);

      // R2: seeds in both lanes (R7)
      for (int ch = 0; ch < CHANS; ch++) begin
         rd(0, ch, 0, v); check("R2 seed lane0", v, ch);
         rd(1, ch, 0, v); check("R2 seed lane1 R7", v, ch);
      end
      // R3: recurrence and wrap, directed
      rd(0, 0, 1, v);   check("R3 ch0 idx1", v, 1);
      rd(1, 9, 2, v);   check("R3 ch9 idx2", v, 12);
      rd(0, 0, 361, v); check("R3 before wrap", v, 65341);
      rd(0, 0, 362, v); check("R3 wrap", v, 167);
      rd(1, 9, 369, v); check("R3 last element lane1", v, int'(exp_val(9, 369)));

      // R3 R4 R7: every element of every bank
      full_readback("R3 R4 R7 full readback");

      // R8: random back-to-back reads, one cycle latency
      begin
         int pl, pc, pi;
         @(negedge clk);
         pl = $urandom % LANES; pc = $urandom % CHANS; pi = $urandom % SEQ;
         rd_lane = LW'(pl); rd_chan = CH_W'(pc); rd_idx = IDX_W'(pi);
         for (int r = 0; r < 300; r++) begin
            int nl, nc, ni;
            @(negedge clk);
            check("R8 back-to-back read", int'(rd_data), int'(exp_val(pc, pi)));
            nl = $urandom % LANES; nc = $urandom % CHANS; ni = $urandom % SEQ;
            rd_lane = LW'(nl); rd_chan = CH_W'(nc); rd_idx = IDX_W'(ni);
            pl = nl; pc = nc; pi = ni;
         end
      end

      // R6: start pulsed mid-run is ignored; R9: restart after done
      run("R6 R9 run2 with mid-run start", 137);
      full_readback("R6 R9 readback after second run");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule